// File: doc/BRIEF.md
# Dot-Clock Raster Timing Generator

This block produces the line and frame timing for a parallel RGB panel that is clocked once per pixel. Two free-running counters walk the raster: a pixel counter across each line and a line counter down the frame. From them it decodes a horizontal sync pulse, a vertical sync pulse, a data-enable window and a one-cycle start-of-frame marker. It also presents the current pixel and line coordinates so that a pixel source can follow the scan.

All timing is set through configuration inputs. Each axis has a total period, a sync width and a wait count. The wait count is measured from the start of the sync pulse to the first active pixel or line. The horizontal axis also has an active pixel count, and the vertical axis an active line count. The vertical sync width and the vertical period are counted in whole lines. Three polarity bits choose active-high or active-low for horizontal sync, vertical sync and data enable. A sync enable input forces both sync outputs to their idle levels without stopping the counters. All configuration, polarity included, is copied into a shadow set at each frame boundary, so a frame in progress always finishes with the values it began with.

Top module: `disp_timing_gen`

## Requirements
- R1: While reset is asserted: hsync, vsync and de are high (the idle level of the active-low default), sof is 0, and pix_x and line_y are 0.
- R2: In the first cycle after reset is released, the outputs show pixel 0 of line 0. pix_x then rises by one each cycle and returns to 0 after the value h_total-1.
- R3: line_y rises by one each time pix_x returns to 0, and it returns to 0 after the value v_total-1.
- R4: sof is 1 in exactly the cycles where pix_x and line_y are both 0.
- R5: The horizontal sync is active while pix_x < h_sync_w. The vertical sync is active while line_y < v_sync_w, so its width is counted in lines. A width of 0 never activates the pulse.
- R6: de is active when h_wait <= pix_x < h_wait+h_active and v_wait <= line_y < v_wait+v_active, and inactive elsewhere.
- R7: Polarity bits hs_high, vs_high and de_high set to 1 make the active level 1. Set to 0, the active level is 0 and the idle level is 1.
- R8: When sync_en is 0 at a clock edge, hsync and vsync show their idle levels in the following cycle. de, sof, pix_x and line_y keep following the raster.
- R9: Configuration and polarity are sampled at the clock edge that moves the raster to pixel 0 of line 0, and at the first edge after reset. A change made at any other time has no effect on the outputs until the next such edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_en | input | 1 | 1 lets the sync pulses through, 0 holds them idle |
| h_total | input | 12 | Pixels per line, all phases included |
| h_sync_w | input | 12 | Horizontal sync width in pixels |
| h_wait | input | 12 | Pixels from line start to first active pixel |
| h_active | input | 12 | Active pixels per line |
| v_total | input | 12 | Lines per frame, all phases included |
| v_sync_w | input | 12 | Vertical sync width in lines |
| v_wait | input | 12 | Lines from frame start to first active line |
| v_active | input | 12 | Active lines per frame |
| hs_high | input | 1 | Horizontal sync active-high when 1 |
| vs_high | input | 1 | Vertical sync active-high when 1 |
| de_high | input | 1 | Data enable active-high when 1 |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| sof | output | 1 | Start-of-frame marker, one cycle |
| pix_x | output | 12 | Current pixel index in the line |
| line_y | output | 12 | Current line index in the frame |

## Verification
Every output is registered from the next-state counters and the next-state shadow configuration. The outputs after a clock edge therefore describe the position the counters took at that edge, and a sync_en value takes effect one edge after it is applied. The bench keeps its own position model and samples on the falling edge, one half cycle after the edge that produced the value. New configuration is adopted by the model only when it was driven during the cycle that shows the last pixel of a frame, because the next edge loads the shadow set. Configuration changes land at random points mid-frame, so every later sample also confirms that mid-frame writes are held off until the boundary.

// File: rtl/tg_pkg.sv
package tg_pkg;
    localparam int H_W = 12;
    localparam int V_W = 12;

    typedef logic [H_W-1:0] hcnt_t;
    typedef logic [V_W-1:0] vcnt_t;

    typedef struct packed {
        hcnt_t h_total;
        hcnt_t h_sync;
        hcnt_t h_wait;
        hcnt_t h_active;
        vcnt_t v_total;
        vcnt_t v_sync;
        vcnt_t v_wait;
        vcnt_t v_active;
        logic  hs_high;
        logic  vs_high;
        logic  de_high;
    } tcfg_t;

    typedef struct packed {
        logic  hsync;
        logic  vsync;
        logic  de;
        logic  sof;
        hcnt_t x;
        vcnt_t y;
    } tout_t;
endpackage

// File: rtl/tg_shadow.sv
module tg_shadow
    import tg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  tcfg_t cfg_i,
    input  logic  frame_end_i,
    output tcfg_t cfg_next_o,
    output hcnt_t h_total_o,
    output vcnt_t v_total_o,
    output logic  primed_o
);
    typedef struct packed {
        tcfg_t cfg;
        logic  primed;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.primed = 1'b1;
        if (!s_q.primed || frame_end_i)
            s_d.cfg = cfg_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_next_o = s_d.cfg;
    assign h_total_o  = s_q.cfg.h_total;
    assign v_total_o  = s_q.cfg.v_total;
    assign primed_o   = s_q.primed;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.primed && !frame_end_i) |=> $stable(s_q.cfg)); // R9
endmodule

// File: rtl/tg_raster.sv
module tg_raster
    import tg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run_i,
    input  hcnt_t h_total_i,
    input  vcnt_t v_total_i,
    output hcnt_t h_next_o,
    output vcnt_t v_next_o,
    output logic  frame_end_o
);
    typedef struct packed {
        hcnt_t h;
        vcnt_t v;
    } cnt_t;

    cnt_t c_d, c_q;
    logic h_last, v_last;

    always_comb begin
        h_last = (c_q.h == h_total_i - hcnt_t'(1));
        v_last = (c_q.v == v_total_i - vcnt_t'(1));
        c_d    = c_q;
        if (run_i) begin
            if (h_last) begin
                c_d.h = '0;
                c_d.v = v_last ? '0 : c_q.v + vcnt_t'(1);
            end else begin
                c_d.h = c_q.h + hcnt_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign h_next_o    = c_d.h;
    assign v_next_o    = c_d.v;
    assign frame_end_o = run_i && h_last && v_last;

    AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !h_last) |=> (c_q.h == $past(c_q.h) + hcnt_t'(1))); // R2
    AST_PIX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && h_last) |=> (c_q.h == '0)); // R2
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && h_last && !v_last) |=> (c_q.v == $past(c_q.v) + vcnt_t'(1))); // R3
endmodule

// File: rtl/tg_decode.sv
module tg_decode
    import tg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sync_en_i,
    input  hcnt_t h_i,
    input  vcnt_t v_i,
    input  tcfg_t cfg_i,
    output tout_t out_o
);
    typedef struct packed {
        tout_t o;
        logic  live;
    } dec_t;

    localparam dec_t DEC_RST = '{o: '{hsync: 1'b1, vsync: 1'b1, de: 1'b1, sof: 1'b0,
                                      x: '0, y: '0}, live: 1'b0};

    dec_t d_d, d_q;
    logic hs_act, vs_act, h_in, v_in, de_act;

    always_comb begin
        hs_act = (h_i < cfg_i.h_sync);
        vs_act = (v_i < cfg_i.v_sync);
        h_in   = (h_i >= cfg_i.h_wait) &&
                 ({1'b0, h_i} < ({1'b0, cfg_i.h_wait} + {1'b0, cfg_i.h_active}));
        v_in   = (v_i >= cfg_i.v_wait) &&
                 ({1'b0, v_i} < ({1'b0, cfg_i.v_wait} + {1'b0, cfg_i.v_active}));
        de_act = h_in && v_in;

        d_d.live    = 1'b1;
        d_d.o.hsync = sync_en_i ? (cfg_i.hs_high ? hs_act : !hs_act) : !cfg_i.hs_high;
        d_d.o.vsync = sync_en_i ? (cfg_i.vs_high ? vs_act : !vs_act) : !cfg_i.vs_high;
        d_d.o.de    = cfg_i.de_high ? de_act : !de_act;
        d_d.o.sof   = (h_i == '0) && (v_i == '0);
        d_d.o.x     = h_i;
        d_d.o.y     = v_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= DEC_RST;
        else        d_q <= d_d;
    end

    assign out_o = d_q.o;

    AST_SOF_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        d_q.o.sof |-> (d_q.o.x == '0 && d_q.o.y == '0)); // R4
    AST_HS_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.live && !$past(sync_en_i)) |-> (d_q.o.hsync == !$past(cfg_i.hs_high))); // R8
    AST_VS_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.live && !$past(sync_en_i)) |-> (d_q.o.vsync == !$past(cfg_i.vs_high))); // R8
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import tg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sync_en,
    input  logic [H_W-1:0] h_total,
    input  logic [H_W-1:0] h_sync_w,
    input  logic [H_W-1:0] h_wait,
    input  logic [H_W-1:0] h_active,
    input  logic [V_W-1:0] v_total,
    input  logic [V_W-1:0] v_sync_w,
    input  logic [V_W-1:0] v_wait,
    input  logic [V_W-1:0] v_active,
    input  logic           hs_high,
    input  logic           vs_high,
    input  logic           de_high,
    output logic           hsync,
    output logic           vsync,
    output logic           de,
    output logic           sof,
    output logic [H_W-1:0] pix_x,
    output logic [V_W-1:0] line_y
);
    tcfg_t cfg_in, cfg_next;
    hcnt_t h_tot_q, h_next;
    vcnt_t v_tot_q, v_next;
    logic  primed, frame_end;
    tout_t outs;

    assign cfg_in = '{h_total: h_total, h_sync: h_sync_w, h_wait: h_wait,
                      h_active: h_active, v_total: v_total, v_sync: v_sync_w,
                      v_wait: v_wait, v_active: v_active, hs_high: hs_high,
                      vs_high: vs_high, de_high: de_high};

    tg_shadow i_shadow (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg_in), .frame_end_i(frame_end),
        .cfg_next_o(cfg_next), .h_total_o(h_tot_q), .v_total_o(v_tot_q),
        .primed_o(primed)
    );

    tg_raster i_raster (
        .clk(clk), .rst_n(rst_n), .run_i(primed), .h_total_i(h_tot_q),
        .v_total_i(v_tot_q), .h_next_o(h_next), .v_next_o(v_next),
        .frame_end_o(frame_end)
    );

    tg_decode i_decode (
        .clk(clk), .rst_n(rst_n), .sync_en_i(sync_en), .h_i(h_next),
        .v_i(v_next), .cfg_i(cfg_next), .out_o(outs)
    );

    assign hsync  = outs.hsync;
    assign vsync  = outs.vsync;
    assign de     = outs.de;
    assign sof    = outs.sof;
    assign pix_x  = outs.x;
    assign line_y = outs.y;
endmodule

// File: tb/test_disp_timing_gen.sv
module test_disp_timing_gen;
    import tg_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic  rst_n, sync_en;
    tcfg_t cfg;
    logic  hsync, vsync, de, sof;
    hcnt_t pix_x;
    vcnt_t line_y;

    disp_timing_gen i_disp_timing_gen (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en),
        .h_total(cfg.h_total), .h_sync_w(cfg.h_sync), .h_wait(cfg.h_wait),
        .h_active(cfg.h_active), .v_total(cfg.v_total), .v_sync_w(cfg.v_sync),
        .v_wait(cfg.v_wait), .v_active(cfg.v_active), .hs_high(cfg.hs_high),
        .vs_high(cfg.vs_high), .de_high(cfg.de_high),
        .hsync(hsync), .vsync(vsync), .de(de), .sof(sof),
        .pix_x(pix_x), .line_y(line_y)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    tcfg_t mcfg;
    int    mx, my;
    bit    men;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (x=%0d y=%0d)", tag, act, exp, mx, my);
        end
    endtask

    function automatic bit lvl(input bit act, input bit high);
        return high ? act : !act;
    endfunction

    function automatic tcfg_t make_cfg(input int ht, input int hs, input int hw, input int ha,
                                       input int vt, input int vs, input int vw, input int va,
                                       input bit hp, input bit vp, input bit dp);
        tcfg_t c;
        c.h_total = hcnt_t'(ht); c.h_sync = hcnt_t'(hs);
        c.h_wait  = hcnt_t'(hw); c.h_active = hcnt_t'(ha);
        c.v_total = vcnt_t'(vt); c.v_sync = vcnt_t'(vs);
        c.v_wait  = vcnt_t'(vw); c.v_active = vcnt_t'(va);
        c.hs_high = hp; c.vs_high = vp; c.de_high = dp;
        return c;
    endfunction

    function automatic tcfg_t rand_cfg();
        int ht, hs, hw, ha, vt, vs, vw, va;
        ht = 6 + int'($urandom_range(0, 11));
        hs = int'($urandom_range(0, 2));
        hw = hs + int'($urandom_range(0, 2));
        ha = int'($urandom_range(1, ht - hw));
        vt = 4 + int'($urandom_range(0, 4));
        vs = int'($urandom_range(0, 2));
        vw = vs + int'($urandom_range(0, 1));
        va = int'($urandom_range(1, vt - vw));
        return make_cfg(ht, hs, hw, ha, vt, vs, vw, va, 1'($urandom_range(0, 1)),
                        1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    endfunction

    function automatic bit exp_de(input int x, input int y, input tcfg_t c);
        bit hin, vin;
        hin = (x >= int'(c.h_wait)) && (x < int'(c.h_wait) + int'(c.h_active));
        vin = (y >= int'(c.v_wait)) && (y < int'(c.v_wait) + int'(c.v_active));
        return lvl(hin && vin, c.de_high);
    endfunction

    task automatic check_pos();
        bit ehs, evs;
        ehs = men ? lvl(mx < int'(mcfg.h_sync), mcfg.hs_high) : !mcfg.hs_high;
        evs = men ? lvl(my < int'(mcfg.v_sync), mcfg.vs_high) : !mcfg.vs_high;
        chk("R2 R9 pix_x", int'(pix_x), mx);
        chk("R3 R9 line_y", int'(line_y), my);
        chk("R4 sof", int'(sof), int'(mx == 0 && my == 0));
        chk("R5 R7 R8 hsync", int'(hsync), int'(ehs));
        chk("R5 R7 R8 vsync", int'(vsync), int'(evs));
        chk("R6 R7 de", int'(de), int'(exp_de(mx, my, mcfg)));
    endtask

    initial begin
        bit last;
        void'($urandom(32'd2024));
        rst_n   = 1'b0;
        sync_en = 1'b1;
        // full-width active window reaching the end of line and frame
        cfg = make_cfg(10, 2, 3, 7, 6, 1, 2, 4, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R1 hsync", int'(hsync), 1);
        chk("R1 vsync", int'(vsync), 1);
        chk("R1 de", int'(de), 1);
        chk("R1 sof", int'(sof), 0);
        chk("R1 pix_x", int'(pix_x), 0);
        chk("R1 line_y", int'(line_y), 0);
        rst_n = 1'b1;
        mcfg = cfg; men = 1'b1; mx = 0; my = 0;
        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            check_pos();
            last = (mx == int'(mcfg.h_total) - 1) && (my == int'(mcfg.v_total) - 1);
            if (cyc == 200) sync_en = 1'b0;            // R8
            if (cyc == 250) sync_en = 1'b1;
            if (cyc == 403)                            // R9 mid-frame, R7 active-high, R5 zero width
                cfg = make_cfg(13, 0, 2, 5, 5, 2, 2, 3, 1'b1, 1'b1, 1'b1);
            if (cyc >= 800 && (cyc % 53) == 17) cfg = rand_cfg();
            if (cyc >= 800 && (cyc % 29) == 5) sync_en = ($urandom_range(0, 7) != 0);
            if (last) mcfg = cfg;                      // R9 boundary capture
            men = sync_en;
            if (mx == int'(mcfg.h_total) - 1 || last) begin
                mx = 0;
                my = last ? 0 : (my + 1 == int'(mcfg.v_total) ? 0 : my + 1);
            end else begin
                mx = mx + 1;
            end
            if (last) my = 0;
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule